// File: doc/BRIEF.md
# Millisecond Timebase and Reaction Timers

This block turns a fast system clock into a one-millisecond timebase and uses it to run two timers for a reaction-time game. A divider produces a one-cycle tick every `DIV` clocks. With the default 50 MHz clock and `DIV` of 50,000, that is one tick per millisecond. The tick stays in the system clock domain, and nothing downstream is clocked by a derived clock.

The first timer is the foreperiod wait. While a controller enables it, the timer counts ticks in an `DELAY_W`-bit register (11 bits by default). When the register reaches all ones it stops there and raises a done flag, which stays up until the controller clears it.

The second timer measures the player's reaction in milliseconds. It advances on each tick while its enable is high. From the first clock edge at which the enable is low, it holds its value. It saturates at its largest value and does not wrap. Each timer has a clear input, and the clear wins over the enable.

All control pins are plain levels sampled on the rising edge. There is no data stream and so no valid/ready handshake: the score is a level output that the controller reads whenever it needs it.

Top module: `rxn_ms_timer`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `ms_tick` and `delay_done` are 0 and `score` is 0.
- R2: `ms_tick` rises exactly `DIV` clock cycles after its previous rise. The first rise comes `DIV` cycles after reset is released.
- R3: `ms_tick` is high for exactly one clock cycle per period.
- R4: With `delay_en` high and `delay_clr` low, the delay count rises by one per tick. `delay_done` goes high after the (2^DELAY_W - 1)th counted tick and not before.
- R5: Once `delay_done` is high, it stays high and the count stays at all ones on further ticks, until `delay_clr` is applied.
- R6: `delay_clr` high forces the delay count to zero on the next edge, even when `delay_en` is high. While `delay_clr` is held, `delay_done` stays low across ticks.
- R7: Ticks that arrive while `delay_en` is low leave the delay count unchanged. Counting resumes from the held value when the enable returns.
- R8: With `score_en` high and `score_clr` low, `score` rises by one on each tick.
- R9: `score` does not change on any edge at which `score_en` is low. This includes the edge that carries a tick when the enable dropped in that same cycle.
- R10: `score` saturates at 2^SCORE_W - 1 (8191 by default) and stays there on further enabled ticks.
- R11: `score_clr` high forces `score` to 0 on the next edge, even when `score_en` is high and a tick arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| delay_en | input | 1 | Lets the foreperiod timer count ticks |
| delay_clr | input | 1 | Zeroes the foreperiod timer; wins over `delay_en` |
| score_en | input | 1 | Lets the reaction timer count ticks |
| score_clr | input | 1 | Zeroes the reaction timer; wins over `score_en` |
| ms_tick | output | 1 | One-cycle pulse every `DIV` clocks |
| delay_done | output | 1 | High while the foreperiod count is all ones |
| score | output | SCORE_W (13) | Reaction time in ticks, saturating |

## Verification
The properties assume that the control inputs are synchronous to `clk` and are stable around the rising edge. They also assume `DIV` is at least 2, so a tick can never sit high in two adjacent cycles. The bench drives every control change on the falling edge and samples on the falling edge. It builds the block with a small divider and narrow counters, so saturation and the done flag are reached within a few dozen ticks. For the same-cycle freeze case, the bench lowers `score_en` on the falling edge at which a tick is already visible, so the block sees the tick and the disable at the same rising edge.

// File: rtl/rxn_timer_pkg.sv
`timescale 1ns/1ps
package rxn_timer_pkg;
  // Default geometry: 50 MHz system clock divided down to 1 kHz.
  localparam int unsigned MS_DIV_DEFAULT  = 50000;
  localparam int unsigned DELAY_W_DEFAULT = 11;
  localparam int unsigned SCORE_W_DEFAULT = 13;

  // Counter width needed to hold values 0 .. n-1 (at least one bit).
  function automatic int unsigned span_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rxn_tick_div.sv
`timescale 1ns/1ps
module rxn_tick_div
  import rxn_timer_pkg::*;
#(
  parameter int unsigned DIV = MS_DIV_DEFAULT
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned   CW   = span_width(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase;
  logic          wrap;

  assign wrap = (phase == LAST);

  // Phase runs 0..DIV-1 and restarts; tick is registered so it is a clean
  // one-cycle pulse in the system clock domain.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      tick  <= 1'b0;
    end else begin
      tick  <= wrap;
      phase <= wrap ? '0 : phase + 1'b1;
    end
  end
endmodule

// File: rtl/rxn_sat_counter.sv
`timescale 1ns/1ps
module rxn_sat_counter #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         full
);
  localparam logic [W-1:0] TOP = '1;

  assign full = (count == TOP);

  // Clear beats enable; a step is taken only when enabled, ticking and below top.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (en && step && !full) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/rxn_ms_timer.sv
`timescale 1ns/1ps
module rxn_ms_timer
  import rxn_timer_pkg::*;
#(
  parameter int unsigned DIV     = MS_DIV_DEFAULT,
  parameter int unsigned DELAY_W = DELAY_W_DEFAULT,
  parameter int unsigned SCORE_W = SCORE_W_DEFAULT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               delay_en,
  input  logic               delay_clr,
  input  logic               score_en,
  input  logic               score_clr,
  output logic               ms_tick,
  output logic               delay_done,
  output logic [SCORE_W-1:0] score
);
  logic [DELAY_W-1:0] delay_count;
  logic               score_full;

  rxn_tick_div #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (ms_tick)
  );

  rxn_sat_counter #(.W(DELAY_W)) u_fore (
    .clk   (clk),
    .rst   (rst),
    .clr   (delay_clr),
    .en    (delay_en),
    .step  (ms_tick),
    .count (delay_count),
    .full  (delay_done)
  );

  rxn_sat_counter #(.W(SCORE_W)) u_react (
    .clk   (clk),
    .rst   (rst),
    .clr   (score_clr),
    .en    (score_en),
    .step  (ms_tick),
    .count (score),
    .full  (score_full)
  );

  // score_full is only needed inside the counter itself.
  logic unused_ok;
  assign unused_ok = score_full;
endmodule

// File: rtl/rxn_ms_timer_chk.sv
`timescale 1ns/1ps
module rxn_ms_timer_chk #(
  parameter int unsigned DIV     = 50000,
  parameter int unsigned DELAY_W = 11,
  parameter int unsigned SCORE_W = 13
) (
  input logic               clk,
  input logic               rst,
  input logic               delay_en,
  input logic               delay_clr,
  input logic               score_en,
  input logic               score_clr,
  input logic               ms_tick,
  input logic               delay_done,
  input logic [SCORE_W-1:0] score,
  input logic [DELAY_W-1:0] delay_count
);
  localparam logic [SCORE_W-1:0] SMAX = '1;
  localparam int unsigned        GW   = $clog2(DIV + 1) + 1;

  // Cycles since the last tick (or since reset), checked by counter, not $past.
  logic [GW-1:0] gap;
  always_ff @(posedge clk) begin
    if (rst)          gap <= '0;
    else if (ms_tick) gap <= GW'(1);
    else              gap <= gap + 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!ms_tick && !delay_done && score == '0));

  p_tick_period_r2: assert property (@(posedge clk) disable iff (rst)
    ms_tick |-> (gap == GW'(DIV)));

  p_tick_early_r2: assert property (@(posedge clk) disable iff (rst)
    !ms_tick |-> (gap < GW'(DIV)));

  p_tick_single_r3: assert property (@(posedge clk) disable iff (rst)
    ms_tick |=> !ms_tick);

  p_delay_step_r4: assert property (@(posedge clk) disable iff (rst)
    (delay_en && !delay_clr && ms_tick && !delay_done)
      |=> (delay_count == DELAY_W'($past(delay_count) + 1'b1)));

  p_done_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (delay_done && !delay_clr) |=> delay_done);

  p_delay_clr_r6: assert property (@(posedge clk) disable iff (rst)
    delay_clr |=> (delay_count == '0 && !delay_done));

  p_delay_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!delay_en && !delay_clr) |=> $stable(delay_count));

  p_score_step_r8: assert property (@(posedge clk) disable iff (rst)
    (score_en && !score_clr && ms_tick && score != SMAX)
      |=> (score == SCORE_W'($past(score) + 1'b1)));

  p_score_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    (!score_en && !score_clr) |=> $stable(score));

  p_score_sat_r10: assert property (@(posedge clk) disable iff (rst)
    (score == SMAX && !score_clr) |=> (score == SMAX));

  p_score_clr_r11: assert property (@(posedge clk) disable iff (rst)
    score_clr |=> (score == '0));
endmodule

bind rxn_ms_timer rxn_ms_timer_chk #(
  .DIV     (DIV),
  .DELAY_W (DELAY_W),
  .SCORE_W (SCORE_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .delay_en    (delay_en),
  .delay_clr   (delay_clr),
  .score_en    (score_en),
  .score_clr   (score_clr),
  .ms_tick     (ms_tick),
  .delay_done  (delay_done),
  .score       (score),
  .delay_count (delay_count)
);

// File: tb/rxn_ms_timer_test.sv
`timescale 1ns/1ps
module rxn_ms_timer_test;
  localparam int DIV  = 8;
  localparam int DW   = 3;
  localparam int SW   = 4;
  localparam int DTOP = (1 << DW) - 1;
  localparam int STOP = (1 << SW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          delay_en = 1'b0, delay_clr = 1'b0;
  logic          score_en = 1'b0, score_clr = 1'b0;
  logic          ms_tick, delay_done;
  logic [SW-1:0] score;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rxn_ms_timer #(.DIV(DIV), .DELAY_W(DW), .SCORE_W(SW)) uut (
    .clk(clk), .rst(rst),
    .delay_en(delay_en), .delay_clr(delay_clr),
    .score_en(score_en), .score_clr(score_clr),
    .ms_tick(ms_tick), .delay_done(delay_done), .score(score)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Waits for n ticks to be seen, then one more falling edge so each is consumed.
  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!ms_tick);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(ms_tick == 1'b0, "R1 tick in reset", ms_tick, 0);
    check(delay_done == 1'b0, "R1 done in reset", delay_done, 0);
    check(score == '0, "R1 score in reset", score, 0);
    rst = 1'b0;
    @(negedge clk);
    check(ms_tick == 1'b0 && delay_done == 1'b0 && score == '0,
          "R1 first cycle after reset", int'(score), 0);
  endtask

  task automatic t_tick;
    int gap;
    // One falling edge has passed since reset release; first tick is DIV cycles after.
    gap = 1;
    while (!ms_tick) begin @(negedge clk); gap++; end
    check(gap == DIV, "R2 first tick spacing", gap, DIV);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check(ms_tick == 1'b0, "R3 tick width", ms_tick, 0);
      gap = 1;
      while (!ms_tick) begin @(negedge clk); gap++; end
      check(gap == DIV, "R2 tick period", gap, DIV);
    end
    @(negedge clk);
  endtask

  task automatic t_delay_run;
    delay_clr = 1'b1; @(negedge clk);
    delay_clr = 1'b0; delay_en = 1'b1;
    run_ticks(DTOP - 1);
    check(delay_done == 1'b0, "R4 done before last tick", delay_done, 0);
    run_ticks(1);
    check(delay_done == 1'b1, "R4 done at all ones", delay_done, 1);
    run_ticks(3);
    check(delay_done == 1'b1, "R5 done held at top", delay_done, 1);
    delay_clr = 1'b1;
    @(negedge clk);
    check(delay_done == 1'b0, "R6 clear beats enable", delay_done, 0);
    run_ticks(DTOP + 1);
    check(delay_done == 1'b0, "R6 held clear across ticks", delay_done, 0);
    delay_clr = 1'b0;
  endtask

  task automatic t_delay_pause;
    run_ticks(3);
    delay_en = 1'b0;
    run_ticks(6);
    delay_en = 1'b1;
    run_ticks(DTOP - 4);
    check(delay_done == 1'b0, "R7 paused ticks not counted", delay_done, 0);
    run_ticks(1);
    check(delay_done == 1'b1, "R7 resumes from held count", delay_done, 1);
    delay_en = 1'b0;
    delay_clr = 1'b1; @(negedge clk); delay_clr = 1'b0;
  endtask

  task automatic t_score;
    score_clr = 1'b1; @(negedge clk);
    score_clr = 1'b0; score_en = 1'b1;
    run_ticks(5);
    check(score == 5, "R8 score after 5 ticks", score, 5);
    run_ticks(3);
    check(score == 8, "R8 score after 8 ticks", score, 8);
    score_en = 1'b0;
    run_ticks(4);
    check(score == 8, "R9 disabled ticks ignored", score, 8);
    score_en = 1'b1;
    run_ticks(1);
    check(score == 9, "R8 counting resumes", score, 9);
    do @(negedge clk); while (!ms_tick);
    score_en = 1'b0;
    @(negedge clk);
    check(score == 9, "R9 freeze on same cycle as tick", score, 9);
    run_ticks(2);
    check(score == 9, "R9 stays frozen", score, 9);
  endtask

  task automatic t_score_sat;
    score_en = 1'b1;
    run_ticks(STOP - 9);
    check(score == STOP, "R10 reaches top", score, STOP);
    run_ticks(3);
    check(score == STOP, "R10 saturates", score, STOP);
  endtask

  task automatic t_score_clr;
    score_clr = 1'b1;
    @(negedge clk);
    check(score == 0, "R11 clear beats enable", score, 0);
    run_ticks(2);
    check(score == 0, "R11 held clear across ticks", score, 0);
    score_clr = 1'b0;
    run_ticks(1);
    check(score == 1, "R11 counts after clear", score, 1);
    score_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_tick();
    t_delay_run();
    t_delay_pause();
    t_score();
    t_score_sat();
    t_score_clr();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule